// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a synchronous static memory with an 18-bit word made of two 9-bit byte lanes. The word depth is set by the address width parameter. A caller starts an access by pulling one of two address strobes low for one clock. That clock edge registers the external word address and the chip enable. The access that follows can step through a group of four words that differ only in their two lowest address bits.

The two strobes have a fixed priority. The processor-side strobe always wins and opens a read. The byte write enables on the next cycle can turn that first access into a late write. The controller-side strobe is used only when the processor-side strobe is high. Its write input is sampled with it and decides whether the burst may write at all.

Once a burst is running, a separate advance input moves it forward. A low advance steps a 2-bit counter before the access. A high advance holds the address and inserts a wait state. Read data is registered. A valid flag marks the cycle in which the output word is meaningful.

Top module: `sbr_burst_sram`

## Requirements
- R1: A strobe sampled at edge k, with the chip enable low, loads the address. The first access takes place at edge k+1 whatever the advance input is. For a read, the word and `dout_vld`=1 are present during the cycle after edge k+1.
- R2: If `ads_p_n` is low at an edge, that edge performs no array access, so any running burst is aborted. The edge loads `addr`, and `we_n` and `ads_c_n` have no effect. The first access of the new burst is a read when both byte enables are high.
- R3: A processor-strobe load followed by one edge with both strobes high and at least one byte enable low writes `din` to the loaded address (two-cycle write).
- R4: If `ads_c_n` is low and `ads_p_n` is high at an edge, the edge aborts any burst and loads `addr`. With `we_n` low, each access of the burst writes the enabled lanes, and an access with both byte enables high reads. With `we_n` high, every access reads and the byte enables are ignored.
- R5: `ce_n` is sampled only at a loading edge. If it is high there, the burst makes no access, so there are no writes and `dout_vld` stays 0. Changes of `ce_n` between loads have no effect.
- R6: At an edge after the first access, with both strobes high, `adv_n` low performs an access at the next address. `adv_n` high is a wait state: no access, `dout_vld` goes to 0, and the address is held.
- R7: The two lowest address bits start at `addr[1:0]` and step by +1 modulo 4. The upper bits stay fixed, so a start of 2 gives the word order 2,3,0,1,2.
- R8: `bwe_lo_n` low writes `din[8:0]` into bits 8:0, and `bwe_hi_n` low writes `din[17:9]` into bits 17:9. A lane whose enable is high keeps its stored contents.
- R9: `dout_vld` is 1 only in the cycle after a read access whose edge sampled `oe_n` low. In every other cycle `dout_vld` is 0 and `dout` is all zeros.
- R10: The synchronous active-high `rst` clears the burst and the captured chip enable. After it, no access occurs and the output stays invalid until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | External word address |
| ads_p_n | input | 1 | Processor-side address strobe, active low, highest priority |
| ads_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Global write, sampled with the controller-side strobe |
| bwe_hi_n | input | 1 | Upper lane write enable, active low |
| bwe_lo_n | input | 1 | Lower lane write enable, active low |
| ce_n | input | 1 | Chip enable, active low, sampled at loads |
| oe_n | input | 1 | Output enable, active low, sampled at read edges |
| din | input | 2*LANE_W | Write data |
| dout | output | 2*LANE_W | Registered read data, zero when not valid |
| dout_vld | output | 1 | Read data valid flag |

## Verification
A loading edge never produces output itself. A read access at edge k+1 after a load at edge k shows its data in the cycle after k+1. Each later advancing edge shows its word one cycle after that edge, and wait-state and abort edges clear the output flag one cycle later. The bench drives the inputs on the falling edge and steps a behavioural model on each rising edge from those same inputs. It then compares `dout` and `dout_vld` on the next falling edge, so every expected value lines up with the single register between an access edge and the outputs.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   // Kind of array access performed at a rising edge
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2
   } acc_kind_e;

   // Width of the burst counter (four words per burst group)
   localparam int unsigned BURST_W = 2;

   // Number of byte lanes in a word
   localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/sbr_burst_ctr.sv
module sbr_burst_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             adv,
   output logic [CNT_W-1:0] cur,
   output logic [CNT_W-1:0] nxt
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_width
      $error("sbr_burst_ctr: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   // Linear order: plain increment wraps modulo 2**CNT_W
   assign nxt = cnt_q + ONE;
   assign cur = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (adv) begin
         cnt_q <= nxt;
      end
   end

   // R7
   step_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && adv) |=> (cur == $past(cur) + ONE));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && !adv) |=> $stable(cur));

endmodule

// File: rtl/sbr_access_ctl.sv
module sbr_access_ctl
   import sbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ads_p_n,
   input  logic              ads_c_n,
   input  logic              adv_n,
   input  logic              we_n,
   input  logic [1:0]        bwe_n,
   input  logic              ce_n,
   output acc_kind_e         acc_kind,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int unsigned HI_W = ADDR_W - BURST_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("sbr_access_ctl: ADDR_W must exceed the burst counter width");
   end

   logic              act_q;
   logic              sel_q;
   logic              first_q;
   logic              wr_ok_q;
   logic [HI_W-1:0]   base_hi_q;

   logic              load;
   logic              live;
   logic              step_adv;
   logic              access;
   logic              any_bwe;
   logic [BURST_W-1:0] low_cur;
   logic [BURST_W-1:0] low_nxt;

   assign load     = !ads_p_n || !ads_c_n;
   assign live     = !load && act_q && sel_q;
   assign step_adv = live && !first_q && !adv_n;
   assign access   = live && (first_q || !adv_n);
   assign any_bwe  = (bwe_n != 2'b11);

   always_comb begin
      if (!access) begin
         acc_kind = ACC_NONE;
      end else if (wr_ok_q && any_bwe) begin
         acc_kind = ACC_WR;
      end else begin
         acc_kind = ACC_RD;
      end
   end

   assign acc_addr = {base_hi_q, (step_adv ? low_nxt : low_cur)};

   sbr_burst_ctr #(
      .CNT_W (BURST_W)
   ) i_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (addr[BURST_W-1:0]),
      .adv      (step_adv),
      .cur      (low_cur),
      .nxt      (low_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q     <= 1'b0;
         sel_q     <= 1'b0;
         first_q   <= 1'b0;
         wr_ok_q   <= 1'b0;
         base_hi_q <= '0;
      end else if (load) begin
         act_q     <= 1'b1;
         sel_q     <= !ce_n;
         first_q   <= 1'b1;
         // processor strobe ignores we_n; a late write stays possible
         wr_ok_q   <= !ads_p_n ? 1'b1 : !we_n;
         base_hi_q <= addr[ADDR_W-1:BURST_W];
      end else if (access) begin
         first_q   <= 1'b0;
      end
   end

   // R2
   p_abort_chk: assert property (@(posedge clk) disable iff (rst)
      !ads_p_n |-> (acc_kind == ACC_NONE));

   // R2
   p_read_chk: assert property (@(posedge clk) disable iff (rst)
      (!ads_p_n && !ce_n) |=>
         (!(ads_p_n && ads_c_n && bwe_n == 2'b11) || acc_kind == ACC_RD));

   // R4
   c_read_chk: assert property (@(posedge clk) disable iff (rst)
      (!ads_c_n && ads_p_n && we_n) |=> (acc_kind != ACC_WR));

   // R5
   desel_chk: assert property (@(posedge clk) disable iff (rst)
      (load && ce_n) |=> (acc_kind == ACC_NONE));

   // R10
   rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && ads_p_n && ads_c_n) |-> (acc_kind == ACC_NONE));

endmodule

// File: rtl/sbr_lane_mem.sv
module sbr_lane_mem #(
   parameter int unsigned LANE_W = 9,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (LANE_W < 1) begin : g_bad_lane
      $error("sbr_lane_mem: LANE_W must be at least 1");
   end

   logic [LANE_W-1:0] mem_q [DEPTH];
   logic [LANE_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[addr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= mem_q[addr];
      end else begin
         rd_q <= '0;
      end
   end

   assign rdata = rd_q;

   // R8
   keep_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (mem_q[$past(addr)] == $past(mem_q[addr])));

   // R9
   rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (rdata != '0) |-> $past(rd_en));

endmodule

// File: rtl/sbr_burst_sram.sv
module sbr_burst_sram
   import sbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANE_W = 9
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  ads_p_n,
   input  logic                  ads_c_n,
   input  logic                  adv_n,
   input  logic                  we_n,
   input  logic                  bwe_hi_n,
   input  logic                  bwe_lo_n,
   input  logic                  ce_n,
   input  logic                  oe_n,
   input  logic [2*LANE_W-1:0]   din,
   output logic [2*LANE_W-1:0]   dout,
   output logic                  dout_vld
);

   localparam int unsigned DATA_W = NUM_LANES * LANE_W;

   if (DATA_W != 2 * LANE_W) begin : g_bad_lanes
      $error("sbr_burst_sram: the word must hold exactly two lanes");
   end

   acc_kind_e         acc_kind;
   logic [ADDR_W-1:0] acc_addr;
   logic [1:0]        bwe_n;
   logic              rd_en;
   logic              vld_q;

   assign bwe_n = {bwe_hi_n, bwe_lo_n};
   assign rd_en = (acc_kind == ACC_RD) && !oe_n;

   sbr_access_ctl #(
      .ADDR_W (ADDR_W)
   ) i_ctl (
      .clk      (clk),
      .rst      (rst),
      .addr     (addr),
      .ads_p_n  (ads_p_n),
      .ads_c_n  (ads_c_n),
      .adv_n    (adv_n),
      .we_n     (we_n),
      .bwe_n    (bwe_n),
      .ce_n     (ce_n),
      .acc_kind (acc_kind),
      .acc_addr (acc_addr)
   );

   for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      logic lane_we;
      assign lane_we = (acc_kind == ACC_WR) && !bwe_n[ln];

      sbr_lane_mem #(
         .LANE_W (LANE_W),
         .ADDR_W (ADDR_W)
      ) i_lane (
         .clk   (clk),
         .rst   (rst),
         .wr_en (lane_we),
         .rd_en (rd_en),
         .addr  (acc_addr),
         .wdata (din[ln*LANE_W +: LANE_W]),
         .rdata (dout[ln*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= rd_en;
      end
   end

   assign dout_vld = vld_q;

   // R9
   vld_oe_chk: assert property (@(posedge clk) disable iff (rst)
      dout_vld |-> $past(!oe_n));

   // R1
   vld_rd_chk: assert property (@(posedge clk) disable iff (rst)
      dout_vld |-> $past(acc_kind == ACC_RD));

   // R3
   wr_bwe_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_kind == ACC_WR) |-> !(bwe_hi_n && bwe_lo_n));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !dout_vld |-> (dout == '0));

endmodule

// File: tb/test_sbr_burst_sram.sv
module test_sbr_burst_sram;

   localparam int AW    = 6;
   localparam int LW    = 9;
   localparam int DW    = 2 * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] addr;
   logic          ads_p_n, ads_c_n, adv_n, we_n, bwe_hi_n, bwe_lo_n, ce_n, oe_n;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_vld;

   always #10 clk = ~clk;

   sbr_burst_sram #(.ADDR_W(AW), .LANE_W(LW)) i_sbr_burst_sram (
      .clk(clk), .rst(rst), .addr(addr), .ads_p_n(ads_p_n), .ads_c_n(ads_c_n),
      .adv_n(adv_n), .we_n(we_n), .bwe_hi_n(bwe_hi_n), .bwe_lo_n(bwe_lo_n),
      .ce_n(ce_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_vld(dout_vld)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   string cur_req = "R10";

   // behavioural reference model
   logic [DW-1:0] m_mem [DEPTH];
   bit            m_act, m_sel, m_first, m_wrok;
   int            m_base, m_off;
   bit            e_v;
   logic [DW-1:0] e_d;

   task automatic model_step();
      bit acc;
      int a;
      if (rst) begin
         m_act = 0; m_sel = 0; m_first = 0; e_v = 0; e_d = '0;
      end else if (!ads_p_n || !ads_c_n) begin
         m_base  = (int'(addr) / 4) * 4;
         m_off   = int'(addr) % 4;
         m_act   = 1;
         m_sel   = !ce_n;
         m_first = 1;
         m_wrok  = !ads_p_n ? 1'b1 : !we_n;
         e_v = 0; e_d = '0;
      end else begin
         acc = 0;
         if (m_act && m_sel) begin
            if (m_first) begin
               acc = 1; m_first = 0;
            end else if (!adv_n) begin
               m_off = (m_off + 1) % 4; acc = 1;
            end
         end
         e_v = 0; e_d = '0;
         if (acc) begin
            a = m_base + m_off;
            if (m_wrok && (!bwe_hi_n || !bwe_lo_n)) begin
               if (!bwe_lo_n) m_mem[a][LW-1:0]  = din[LW-1:0];
               if (!bwe_hi_n) m_mem[a][DW-1:LW] = din[DW-1:LW];
            end else if (!oe_n) begin
               e_v = 1; e_d = m_mem[a];
            end
         end
      end
   endtask

   task automatic compare();
      n_chk++;
      if (dout_vld !== e_v || dout !== e_d) begin
         n_fail++;
         $display("FAIL %s: dout_vld=%0b dout=%h expected dout_vld=%0b dout=%h",
                  cur_req, dout_vld, dout, e_v, e_d);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic set_idle();
      ads_p_n = 1; ads_c_n = 1; adv_n = 1; we_n = 1; bwe_hi_n = 1; bwe_lo_n = 1;
   endtask

   task automatic go_c(input int a, input bit we, input bit ce);
      set_idle(); ads_c_n = 0; addr = AW'(a); we_n = we; ce_n = ce; tick();
      ce_n = 0;
   endtask

   task automatic go_p(input int a, input bit c_too, input bit we);
      set_idle(); ads_p_n = 0; ads_c_n = !c_too; we_n = we; addr = AW'(a); ce_n = 0; tick();
   endtask

   task automatic step(input bit adv, input bit bh, input bit bl, input logic [DW-1:0] d);
      set_idle(); adv_n = adv; bwe_hi_n = bh; bwe_lo_n = bl; din = d; tick();
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(a * 7919 + 12345);
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      rst = 1; set_idle(); addr = '0; ce_n = 0; oe_n = 0; din = '0;
      // R10: reset state
      cur_req = "R10";
      tick(); tick();
      rst = 0;
      step(0, 1, 1, '0);
      step(0, 0, 0, 18'h1);

      // R4 / R8: fill every word with write bursts, both lanes
      cur_req = "R4";
      for (int j = 0; j < DEPTH / 4; j++) begin
         go_c(4 * j, 0, 0);
         step(1, 0, 0, pat(4 * j));
         for (int k = 1; k < 4; k++) step(0, 0, 0, pat(4 * j + k));
      end

      // R7 / R1: read burst starting at low bits 2 wraps 2,3,0,1,2
      cur_req = "R7";
      go_c(6, 1, 0);
      step(1, 1, 1, '0);
      for (int k = 0; k < 4; k++) step(0, 1, 1, '0);

      // R6: wait states hold the address
      cur_req = "R6";
      go_c(9, 1, 0);
      step(1, 1, 1, '0);
      step(1, 1, 1, '0);
      step(0, 1, 1, '0);
      step(1, 1, 1, '0);
      step(1, 1, 1, '0);
      step(0, 1, 1, '0);

      // R2: processor strobe with controller strobe and write low still reads
      cur_req = "R2";
      go_p(13, 1, 0);
      step(1, 1, 1, '0);
      step(0, 1, 1, '0);
      step(0, 1, 1, '0);

      // R3 / R8: two-cycle write to the upper lane only, then read back
      cur_req = "R3";
      go_p(20, 0, 1);
      step(1, 0, 1, 18'h3FFFF);
      go_c(20, 1, 0);
      step(1, 1, 1, '0);

      // R8: lower-lane write, upper-lane write, then a read inside a write burst
      cur_req = "R8";
      go_c(24, 0, 0);
      step(1, 1, 0, 18'h155AA);
      step(0, 0, 1, 18'h2AB55);
      step(0, 1, 1, '0);
      go_c(24, 1, 0);
      step(1, 1, 1, '0);
      step(0, 1, 1, '0);

      // R4: write input high makes byte enables ignored
      cur_req = "R4";
      go_c(30, 1, 0);
      step(1, 0, 0, 18'h0BEEF);
      step(0, 0, 0, 18'h0CAFE);
      go_c(30, 1, 0);
      step(1, 1, 1, '0);
      step(0, 1, 1, '0);

      // R5: deselected burst makes no access; ce changes mid-burst ignored
      cur_req = "R5";
      go_c(40, 0, 1);
      step(1, 0, 0, 18'h12345);
      step(0, 0, 0, 18'h23456);
      go_c(40, 1, 0);
      step(1, 1, 1, '0);
      ce_n = 1;
      step(0, 1, 1, '0);
      step(0, 1, 1, '0);
      ce_n = 0;

      // R9: output enable high suppresses valid data
      cur_req = "R9";
      go_c(48, 1, 0);
      oe_n = 1;
      step(1, 1, 1, '0);
      oe_n = 0;
      step(0, 1, 1, '0);
      oe_n = 1;
      step(0, 1, 1, '0);
      oe_n = 0;

      // R2 / R4: a new strobe aborts a running write burst
      cur_req = "R4";
      go_c(50, 0, 0);
      step(1, 0, 0, 18'h11111);
      set_idle(); ads_c_n = 0; addr = AW'(52); we_n = 1; adv_n = 0;
      bwe_hi_n = 0; bwe_lo_n = 0; din = 18'h22222; tick();
      step(1, 1, 1, '0);
      go_c(48, 1, 0);
      step(1, 1, 1, '0);
      for (int k = 0; k < 3; k++) step(0, 1, 1, '0);

      // R10: reset in mid-burst stops all access until a new strobe
      cur_req = "R10";
      go_c(56, 1, 0);
      step(1, 1, 1, '0);
      rst = 1; tick(); rst = 0;
      step(0, 1, 1, '0);
      step(0, 0, 0, 18'h3AAAA);
      go_c(56, 1, 0);
      step(1, 1, 1, '0);
      step(0, 1, 1, '0);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

endmodule